// File: doc/BRIEF.md
# Serial Position Word Shift Interface

This block hands an absolute position word to a host over a single serial line. A 16-bit word arrives in parallel from the system clock domain. A host drives three plain inputs: a level-controlled load/shift select, a serial clock and a serial input. While the select is high the register follows the word continuously, and the line shows the word's top bit. When the select is low, each rising edge of the serial clock moves the register up by one place. The top bit therefore leaves first, the four interpolated fraction bits leave last, and the host samples on the falling edge.

The host sets the read length by counting its clock pulses. Sixteen pulses return the full word. Twelve to fifteen pulses return a shorter word, counted from the top, and raising the select then starts a fresh read. The serial input feeds the bottom of the register. Several units can therefore be chained, or one unit can be looped back on itself as a ring. A static control inverts the top bit as it is loaded, which reverses the apparent count direction.

The serial clock can run at up to 16 MHz, so a full word moves in about 1 µs. The select, clock and data pins are taken into a faster system clock through two-flop synchronizers, and clock edges are found there. The system clock must therefore run several times faster than the serial clock.

Top module: `pos_shift_out`

## Requirements
- R1: While reset is asserted, the serial output is 0.
- R2: When the select is 1 (load mode), the serial output shows bit 15 of the position word and follows changes to that word.
- R3: When the select is 0 (shift mode), each serial clock rising edge advances the output by one bit. The order is bit 15 first, then down to bit 0.
- R4: A falling edge of the serial clock leaves the serial output unchanged.
- R5: When the invert control is 1, bit 15 is inverted as it is loaded, and bits 14 to 0 are loaded unchanged.
- R6: In shift mode, the serial input enters at bit 0. After 16 rising edges without a reload, the output presents the received bits in their order of arrival.
- R7: Returning the select to 1 after any number of pulses (for example 12) reloads the word, and the next read starts again from bit 15.
- R8: In shift mode with the serial clock idle, changes to the position word do not reach the output.
- R9: A serial clock rising edge changes the output on the third system clock edge after the pin changes, and not on the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pos_word | input | 16 | Position word in the system clock domain; bit 15 goes out first |
| sel_load | input | 1 | 1 = load mode, 0 = shift mode |
| sclk | input | 1 | Serial clock from the host; it idles high |
| sdin | input | 1 | Serial input for cascade or ring operation |
| msb_flip | input | 1 | 1 = invert bit 15 when loading |
| sdout | output | 1 | Serial data output |

## Verification
The register holds the only state that the host can see, so any error in it reaches the line at a predictable pulse. A wrongly loaded bit k shows up at rising edge 15-k. A wrong fill from the serial input shows up after edge 16 plus the bit's arrival index. A missed or doubled edge detection shifts every later bit by one place from that pulse onward. A wrong synchronizer depth moves every change by a whole system cycle, which the third-edge sampling exposes at once.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int unsigned WORD_W      = 16;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    MODE_SHIFT = 1'b0,
    MODE_LOAD  = 1'b1
  } pss_mode_e;
endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [STAGES-1:0][W-1:0] pipe;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/pss_edge.sv
module pss_edge #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= IDLE;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  // R4: one serial edge yields exactly one step pulse
  p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pss_shreg.sv
module pss_shreg
  import pss_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  pss_mode_e    mode,
  input  logic         step,
  input  logic         din,
  input  logic [W-1:0] word,
  input  logic         invert,
  output logic         dout
);
  localparam int unsigned TOP = W - 1;

  logic [W-1:0] sreg;
  logic [W-1:0] load_val;

  always_comb begin
    load_val      = word;
    load_val[TOP] = word[TOP] ^ invert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
    end else if (mode == MODE_LOAD) begin
      sreg <= load_val;
    end else if (step) begin
      sreg <= {sreg[TOP-1:0], din};
    end
  end

  assign dout = sreg[TOP];

  p_load_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LOAD) |=> sreg[TOP-1:0] == $past(word[TOP-1:0]));

  p_load_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LOAD) |=> sreg[TOP] == ($past(word[TOP]) ^ $past(invert)));

  p_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SHIFT && step) |=> sreg[0] == $past(din));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SHIFT && !step) |=> $stable(sreg));
endmodule

// File: rtl/pos_shift_out.sv
module pos_shift_out
  import pss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] pos_word,
  input  logic              sel_load,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              msb_flip,
  output logic              sdout
);
  localparam int unsigned NPIN = 3;

  logic [NPIN-1:0] pins_s;
  logic            sel_s, sclk_s, sdin_s, step;
  pss_mode_e       mode;

  pss_sync #(
    .W       (NPIN),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b110)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({sel_load, sclk, sdin}),
    .q_sync  (pins_s)
  );

  assign {sel_s, sclk_s, sdin_s} = pins_s;
  assign mode = sel_s ? MODE_LOAD : MODE_SHIFT;

  pss_edge #(.IDLE(1'b1)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (sclk_s),
    .rise  (step)
  );

  pss_shreg #(.W(WORD_W)) u_shreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .step   (step),
    .din    (sdin_s),
    .word   (pos_word),
    .invert (msb_flip),
    .dout   (sdout)
  );

  p_reset_out_r1: assert property (@(posedge clk)
    !rst_n |-> sdout == 1'b0);
endmodule

// File: tb/pos_shift_out_tb.sv
module pos_shift_out_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pos_word = '0;
  logic        sel_load = 1'b1;
  logic        sclk = 1'b1;
  logic        sdin = 1'b0;
  logic        msb_flip = 1'b0;
  logic        sdout;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pos_shift_out u_dut (
    .clk(clk), .rst_n(rst_n), .pos_word(pos_word), .sel_load(sel_load),
    .sclk(sclk), .sdin(sdin), .msb_flip(msb_flip), .sdout(sdout)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic din_bit);
    sclk = 1'b0;
    sdin = din_bit;
    wait_clk(HALF_SCK);
    sclk = 1'b1;
    wait_clk(HALF_SCK);
  endtask

  task automatic load_word(input logic [15:0] w, input logic inv);
    sel_load = 1'b1;
    pos_word = w;
    msb_flip = inv;
    wait_clk(6);
  endtask

  task automatic enter_shift();
    sel_load = 1'b0;
    wait_clk(6);
  endtask

  task automatic t_reset();
    wait_clk(3);
    chk("R1 reset output", sdout, 1'b0);
    rst_n = 1'b1;
    wait_clk(2);
  endtask

  task automatic t_load_track();
    load_word(16'h8001, 1'b0);
    chk("R2 load shows bit15=1", sdout, 1'b1);
    pos_word = 16'h7FFF;
    wait_clk(2);
    chk("R2 load follows word", sdout, 1'b0);
  endtask

  task automatic t_full_read(input logic [15:0] w);
    load_word(w, 1'b0);
    enter_shift();
    chk("R3 first bit", sdout, w[15]);
    for (int i = 1; i < 16; i++) begin
      pulse(1'b0);
      chk("R3 bit order", sdout, w[15-i]);
    end
  endtask

  task automatic t_falling();
    logic seen;
    load_word(16'hA000, 1'b0);
    enter_shift();
    pulse(1'b0);
    seen = sdout;
    chk("R4 after rise", seen, 1'b0);
    sclk = 1'b0;
    wait_clk(6);
    chk("R4 falling edge no change", sdout, seen);
    sclk = 1'b1;
    wait_clk(HALF_SCK);
    chk("R4 next rise advances", sdout, 1'b1);
  endtask

  task automatic t_invert();
    logic [15:0] w;
    w = 16'h4BCD;
    load_word(w, 1'b1);
    chk("R5 inverted top bit", sdout, 1'b1);
    enter_shift();
    for (int i = 1; i < 16; i++) begin
      pulse(1'b0);
      chk("R5 lower bits unchanged", sdout, w[15-i]);
    end
    msb_flip = 1'b0;
  endtask

  task automatic t_cascade();
    logic [15:0] p;
    p = 16'hC35A;
    load_word(16'h0000, 1'b0);
    enter_shift();
    for (int k = 0; k < 16; k++) pulse(p[15-k]);
    chk("R6 first arrived bit", sdout, p[15]);
    for (int j = 1; j < 16; j++) begin
      pulse(1'b0);
      chk("R6 arrival order", sdout, p[15-j]);
    end
  endtask

  task automatic t_truncated();
    logic [15:0] w;
    w = 16'h9F31;
    load_word(w, 1'b0);
    enter_shift();
    for (int i = 0; i < 12; i++) pulse(1'b0);
    chk("R7 after 12 pulses", sdout, w[3]);
    load_word(w, 1'b0);
    chk("R7 reload restarts at bit15", sdout, w[15]);
    enter_shift();
    pulse(1'b0);
    chk("R7 restart second bit", sdout, w[14]);
  endtask

  task automatic t_idle_hold();
    load_word(16'hFFFF, 1'b0);
    enter_shift();
    pos_word = 16'h0000;
    wait_clk(8);
    chk("R8 idle shift ignores word", sdout, 1'b1);
    pulse(1'b0);
    chk("R8 held bit14", sdout, 1'b1);
  endtask

  task automatic t_latency();
    load_word(16'h4000, 1'b0);
    enter_shift();
    sclk = 1'b0;
    wait_clk(HALF_SCK);
    sclk = 1'b1;
    wait_clk(2);
    chk("R9 not yet on second edge", sdout, 1'b0);
    wait_clk(1);
    chk("R9 changed on third edge", sdout, 1'b1);
    wait_clk(1);
  endtask

  initial begin
    t_reset();
    t_load_track();
    t_full_read(16'hA5C3);
    t_full_read(16'h1E87);
    t_falling();
    t_invert();
    t_cascade();
    t_truncated();
    t_idle_hold();
    t_latency();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule